// File: doc/BRIEF.md
# USB Control Transfer Stage Sequencer

This block follows a USB device through the stages of a control transfer on endpoint zero. It covers setup, an optional data stage and the status stage, for requests that read, requests that write and requests with no data. It takes decoded bus events, one per clock: token arrivals, data packets with their PID parity, the completion of a transaction with an ACK, and the completion of a setup packet together with the request's direction bit and a flag that says the length field is nonzero. From these it keeps a 3-bit stage code and raises an interrupt status bit for each kind of stage change. Each of those bits has its own enable.

When the host breaks the expected ordering, the block enters a sequence-error stage and switches the endpoint response to STALL. The error code then stays in place until software acknowledges it with a clear pulse. If a complete setup packet arrives during that hold, the block remembers it, along with its direction and length flags. The clear then moves the block straight into the stage that request calls for and raises the setup-end status at that point.

Top module: `usb_ctl_stage_seq`

## Requirements
- R1: After reset the stage code is 000, all status bits are 0, `irq` is 0 and `resp_pid` is 2'b01 (normal response).
- R2: A completed setup (`setup_done`) outside the error stage selects the next stage. It is 001 (read data) for an IN request with a nonzero length, 011 (write data) for an OUT request with a nonzero length, and 101 (no-data status) when the length is zero. The stage code never takes the value 111.
- R3: In stage 001, an OUT or PING token (`tok_kind` 2 or 3) before any ACKed transaction is a sequence error. After at least one ACK, such a token moves the stage to 010 (read status) and raises the data-end status.
- R4: In stage 010, a data packet with DATA0 parity (`rx_data1`=0) is a sequence error, and so is an IN token (`tok_kind` 1). An ACKed transaction ends the transfer, whatever the packet length: the stage returns to 000 and the status-end bit is raised.
- R5: In stage 011, an IN token before any ACK is a sequence error, and so is a DATA0 packet before any ACK. Any number of ACKed OUT packets beyond the request length is accepted without error. An IN token after an ACK moves the stage to 100 (write status) and raises the data-end status.
- R6: In stages 100 and 101, an OUT or PING token is a sequence error. An ACKed transaction returns the stage to 000 and raises the status-end bit.
- R7: A sequence error sets the stage to 110 and `resp_pid` to 2'b10 (STALL). The code stays at 110 through any other traffic, including SETUP tokens, until `sw_clr` is pulsed.
- R8: A `setup_done` that arrives while the code is held at 110 sets no status bit at once. On the next `sw_clr`, the stage goes to the code R2 gives for the held request, `resp_pid` returns to 2'b01 and the setup-end bit is raised.
- R9: Outside the held error stage, a SETUP token (`tok_kind` 0) returns the stage to 000 and sets `resp_pid` to 2'b01. If `sw_clr` empties the error stage with no held setup, the stage returns to 000 and the STALL response remains until the next SETUP token.
- R10: `irq_sts` bit 0 is setup end, bit 1 is data end, bit 2 is status end and bit 3 is sequence error. A bit is set only if the matching `int_en` bit is 1. `sw_clr` clears all bits, and `irq` is 1 exactly when any bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tok_vld | input | 1 | A token was received this cycle |
| tok_kind | input | 2 | Token type: 0 SETUP, 1 IN, 2 OUT, 3 PING |
| setup_done | input | 1 | The setup packet was received and ACKed |
| req_dir_in | input | 1 | Request direction bit, 1 for device-to-host |
| req_wlen_nz | input | 1 | Request length field is nonzero |
| rx_vld | input | 1 | A data packet was received from the host |
| rx_data1 | input | 1 | PID parity of that packet, 1 for DATA1 |
| hs_ack | input | 1 | The current transaction completed with ACK |
| sw_clr | input | 1 | Software clear of the interrupt status |
| int_en | input | 4 | Per-source interrupt enables |
| stage | output | 3 | Current stage code |
| irq_sts | output | 4 | Interrupt status bits |
| irq | output | 1 | OR of the status bits |
| resp_pid | output | 2 | Endpoint response, 2'b10 means STALL |

## Verification
The hardest state to reach is the deferred setup. The block must first be driven into a particular stage by a legal run of tokens and ACKs. Then the one illegal event for that stage is injected. After that, SETUP tokens, IN tokens, ACKs and a complete setup must all be offered while the code is held. The bench walks eight such error paths, one per error rule. On alternate paths it adds a held setup, which checks the jump to the routed stage after the clear; on the other paths it checks the plain return to 000 with STALL still in place. Ahead of these runs, a full sweep of the enable masks against every request type checks each status bit.

// File: rtl/usb_cts_pkg.sv
package usb_cts_pkg;

    typedef enum logic [2:0] {
        ST_SETUP   = 3'd0,
        ST_RD_DATA = 3'd1,
        ST_RD_STAT = 3'd2,
        ST_WR_DATA = 3'd3,
        ST_WR_STAT = 3'd4,
        ST_ND_STAT = 3'd5,
        ST_SEQ_ERR = 3'd6
    } stage_e;

    typedef enum logic [1:0] {
        TK_SETUP = 2'd0,
        TK_IN    = 2'd1,
        TK_OUT   = 2'd2,
        TK_PING  = 2'd3
    } tok_e;

    localparam int NSRC      = 4;
    localparam int SRC_SETUP = 0;
    localparam int SRC_DATA  = 1;
    localparam int SRC_STAT  = 2;
    localparam int SRC_ERR   = 3;

    localparam logic [1:0] RESP_OK    = 2'b01;
    localparam logic [1:0] RESP_STALL = 2'b10;

    typedef struct packed {
        stage_e            stage;
        logic              dat_seen;
        logic              stall;
        logic              pend;
        logic              pend_dir;
        logic              pend_wlen;
        logic [NSRC-1:0]   sts;
    } cts_state_t;

endpackage

// File: rtl/cts_route.sv
module cts_route
    import usb_cts_pkg::*;
(
    input  logic   dir_in,
    input  logic   wlen_nz,
    output stage_e next_stage
);
    always_comb begin
        if (!wlen_nz)
            next_stage = ST_ND_STAT;
        else if (dir_in)
            next_stage = ST_RD_DATA;
        else
            next_stage = ST_WR_DATA;
    end
endmodule

// File: rtl/cts_seq_check.sv
module cts_seq_check
    import usb_cts_pkg::*;
(
    input  stage_e     cur_stage,
    input  logic       dat_seen,
    input  logic       tok_vld,
    input  logic [1:0] tok_kind,
    input  logic       rx_vld,
    input  logic       rx_data1,
    output logic       seq_err
);
    logic tok_in;
    logic tok_outping;

    assign tok_in      = tok_vld && (tok_kind == TK_IN);
    assign tok_outping = tok_vld && (tok_kind == TK_OUT || tok_kind == TK_PING);

    always_comb begin
        unique case (cur_stage)
            ST_RD_DATA: seq_err = tok_outping && !dat_seen;
            ST_RD_STAT: seq_err = (rx_vld && !rx_data1) || tok_in;
            ST_WR_DATA: seq_err = !dat_seen && (tok_in || (rx_vld && !rx_data1));
            ST_WR_STAT,
            ST_ND_STAT: seq_err = tok_outping;
            default:    seq_err = 1'b0;
        endcase
    end
endmodule

// File: rtl/usb_ctl_stage_seq.sv
module usb_ctl_stage_seq
    import usb_cts_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tok_vld,
    input  logic [1:0]      tok_kind,
    input  logic            setup_done,
    input  logic            req_dir_in,
    input  logic            req_wlen_nz,
    input  logic            rx_vld,
    input  logic            rx_data1,
    input  logic            hs_ack,
    input  logic            sw_clr,
    input  logic [NSRC-1:0] int_en,
    output logic [2:0]      stage,
    output logic [NSRC-1:0] irq_sts,
    output logic            irq,
    output logic [1:0]      resp_pid
);
    cts_state_t q, d;
    stage_e     route_stage;
    logic       seq_err;
    logic       held;
    logic       route_dir;
    logic       route_wlen;
    logic       setup_tok;
    logic       tok_in;
    logic       tok_outping;

    assign held        = (q.stage == ST_SEQ_ERR);
    assign route_dir   = held ? q.pend_dir  : req_dir_in;
    assign route_wlen  = held ? q.pend_wlen : req_wlen_nz;
    assign setup_tok   = tok_vld && (tok_kind == TK_SETUP);
    assign tok_in      = tok_vld && (tok_kind == TK_IN);
    assign tok_outping = tok_vld && (tok_kind == TK_OUT || tok_kind == TK_PING);

    cts_route u_route (
        .dir_in     (route_dir),
        .wlen_nz    (route_wlen),
        .next_stage (route_stage)
    );

    cts_seq_check u_check (
        .cur_stage (q.stage),
        .dat_seen  (q.dat_seen),
        .tok_vld   (tok_vld),
        .tok_kind  (tok_kind),
        .rx_vld    (rx_vld),
        .rx_data1  (rx_data1),
        .seq_err   (seq_err)
    );

    always_comb begin
        d = q;
        if (held) begin
            if (setup_done) begin
                d.pend      = 1'b1;
                d.pend_dir  = req_dir_in;
                d.pend_wlen = req_wlen_nz;
            end
            if (sw_clr) begin
                d.sts      = '0;
                d.dat_seen = 1'b0;
                d.pend     = 1'b0;
                if (q.pend) begin
                    d.stage              = route_stage;
                    d.stall              = 1'b0;
                    d.sts[SRC_SETUP]     = int_en[SRC_SETUP];
                end else begin
                    d.stage = ST_SETUP;
                end
            end
        end else begin
            if (sw_clr)
                d.sts = '0;
            if (setup_tok) begin
                d.stage    = ST_SETUP;
                d.stall    = 1'b0;
                d.dat_seen = 1'b0;
            end else if (setup_done) begin
                d.stage          = route_stage;
                d.dat_seen       = 1'b0;
                d.sts[SRC_SETUP] = d.sts[SRC_SETUP] | int_en[SRC_SETUP];
            end else if (seq_err) begin
                d.stage        = ST_SEQ_ERR;
                d.stall        = 1'b1;
                d.pend         = 1'b0;
                d.sts[SRC_ERR] = d.sts[SRC_ERR] | int_en[SRC_ERR];
            end else begin
                unique case (q.stage)
                    ST_RD_DATA: begin
                        if (hs_ack)
                            d.dat_seen = 1'b1;
                        if (tok_outping) begin
                            d.stage         = ST_RD_STAT;
                            d.sts[SRC_DATA] = d.sts[SRC_DATA] | int_en[SRC_DATA];
                        end
                    end
                    ST_WR_DATA: begin
                        if (hs_ack)
                            d.dat_seen = 1'b1;
                        if (tok_in) begin
                            d.stage         = ST_WR_STAT;
                            d.sts[SRC_DATA] = d.sts[SRC_DATA] | int_en[SRC_DATA];
                        end
                    end
                    ST_RD_STAT,
                    ST_WR_STAT,
                    ST_ND_STAT: begin
                        if (hs_ack) begin
                            d.stage         = ST_SETUP;
                            d.dat_seen      = 1'b0;
                            d.sts[SRC_STAT] = d.sts[SRC_STAT] | int_en[SRC_STAT];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{stage: ST_SETUP, dat_seen: 1'b0, stall: 1'b0, pend: 1'b0,
                   pend_dir: 1'b0, pend_wlen: 1'b0, sts: '0};
        end else begin
            q <= d;
        end
    end

    assign stage    = q.stage;
    assign irq_sts  = q.sts;
    assign irq      = |q.sts;
    assign resp_pid = q.stall ? RESP_STALL : RESP_OK;

endmodule

// File: rtl/usb_cts_checker.sv
module usb_cts_checker
    import usb_cts_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            tok_vld,
    input logic [1:0]      tok_kind,
    input logic            sw_clr,
    input logic [NSRC-1:0] int_en,
    input logic [2:0]      stage,
    input logic [NSRC-1:0] irq_sts,
    input logic [1:0]      resp_pid
);
    // R2: the unused code never appears
    a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        stage != 3'b111);

    // R7: the error stage always carries the STALL response
    a_r7_stall_in_err: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == 3'b110) |-> resp_pid == RESP_STALL);

    // R7: without a clear the error code is held
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == 3'b110 && !sw_clr) |=> stage == 3'b110);

    // R7/R8: a clear always leaves the error stage
    a_r8_clear_leaves: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == 3'b110 && sw_clr) |=> stage != 3'b110);

    // R9: a SETUP token outside the hold restarts with a normal response
    a_r9_setup_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (stage != 3'b110 && tok_vld && tok_kind == 2'd0)
        |=> (stage == 3'b000 && resp_pid == RESP_OK));

    // R10: a newly set status bit must have been enabled
    a_r10_masked_sts: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq_sts & ~$past(irq_sts) & ~$past(int_en)) == '0));
endmodule

bind usb_ctl_stage_seq usb_cts_checker u_cts_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .tok_vld  (tok_vld),
    .tok_kind (tok_kind),
    .sw_clr   (sw_clr),
    .int_en   (int_en),
    .stage    (stage),
    .irq_sts  (irq_sts),
    .resp_pid (resp_pid)
);

// File: tb/tb_usb_ctl_stage_seq.sv
module tb_usb_ctl_stage_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tok_vld = 1'b0;
    logic [1:0] tok_kind = 2'd0;
    logic       setup_done = 1'b0;
    logic       req_dir_in = 1'b0;
    logic       req_wlen_nz = 1'b0;
    logic       rx_vld = 1'b0;
    logic       rx_data1 = 1'b0;
    logic       hs_ack = 1'b0;
    logic       sw_clr = 1'b0;
    logic [3:0] int_en = 4'hF;
    logic [2:0] stage;
    logic [3:0] irq_sts;
    logic       irq;
    logic [1:0] resp_pid;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    usb_ctl_stage_seq dut (
        .clk(clk), .rst_n(rst_n), .tok_vld(tok_vld), .tok_kind(tok_kind),
        .setup_done(setup_done), .req_dir_in(req_dir_in), .req_wlen_nz(req_wlen_nz),
        .rx_vld(rx_vld), .rx_data1(rx_data1), .hs_ack(hs_ack), .sw_clr(sw_clr),
        .int_en(int_en), .stage(stage), .irq_sts(irq_sts), .irq(irq), .resp_pid(resp_pid)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int route(input int d, input int w);
        return (w != 0) ? ((d != 0) ? 1 : 3) : 5;
    endfunction

    task automatic tok(input logic [1:0] k);
        tok_vld = 1'b1; tok_kind = k; @(negedge clk); tok_vld = 1'b0;
    endtask
    task automatic sdone(input logic d, input logic w);
        setup_done = 1'b1; req_dir_in = d; req_wlen_nz = w;
        @(negedge clk); setup_done = 1'b0;
    endtask
    task automatic rx(input logic d1);
        rx_vld = 1'b1; rx_data1 = d1; @(negedge clk); rx_vld = 1'b0;
    endtask
    task automatic ack();
        hs_ack = 1'b1; @(negedge clk); hs_ack = 1'b0;
    endtask
    task automatic clr();
        sw_clr = 1'b1; @(negedge clk); sw_clr = 1'b0;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 stage", stage, 0);
        chk("R1 sts", irq_sts, 0);
        chk("R1 irq", irq, 0);
        chk("R1 resp", resp_pid, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep of enable masks against every request type (R2..R6, R10)
        for (int en = 0; en < 16; en++) begin
            for (int rq = 0; rq < 4; rq++) begin
                automatic int d = rq & 1;
                automatic int w = rq >> 1;
                automatic int es = 0;
                int_en = en[3:0];
                clr();
                tok(2'd0);
                chk("R9 restart", stage, 0);
                sdone(d[0], w[0]);
                es = en & 1;
                chk("R2 route", stage, route(d, w));
                chk("R10 setup bit", irq_sts, es);
                if (w != 0 && d != 0) begin
                    tok(2'd1); ack(); tok(2'd1); ack();
                    chk("R3 still data", stage, 1);
                    tok((en & 2) != 0 ? 2'd2 : 2'd3);
                    es |= en & 2;
                    chk("R3 to status", stage, 2);
                    chk("R3 data bit", irq_sts, es);
                    tok(2'd2); rx(1'b1); ack();
                end else if (w != 0) begin
                    for (int k = 0; k < 3; k++) begin
                        tok(2'd2); rx(k[0] ? 1'b0 : 1'b1); ack();
                    end
                    chk("R5 over length no error", stage, 3);
                    chk("R5 response", resp_pid, 1);
                    tok(2'd1);
                    es |= en & 2;
                    chk("R5 to status", stage, 4);
                    chk("R5 data bit", irq_sts, es);
                    ack();
                end else begin
                    tok(2'd1); ack();
                end
                es |= en & 4;
                chk("R4/R6 done", stage, 0);
                chk("R10 status bits", irq_sts, es);
                chk("R10 irq", irq, (es != 0) ? 1 : 0);
                clr();
                chk("R10 clear", irq_sts, 0);
            end
        end

        // Error paths (R3..R8)
        int_en = 4'hF;
        for (int idx = 0; idx < 8; idx++) begin
            automatic int rd = (idx & 1) | ((idx >> 2) & 1);
            automatic int rw = idx >> 1 & 1;
            tok(2'd0);
            case (idx)
                0: begin sdone(1, 1); clr(); tok(2'd2); end          // R3 OUT before ACK
                1: begin sdone(1, 1); clr(); tok(2'd3); end          // R3 PING before ACK
                2: begin sdone(1, 1); tok(2'd1); ack(); tok(2'd2);   // R4 DATA0 status
                         clr(); rx(1'b0); end
                3: begin sdone(1, 1); tok(2'd1); ack(); tok(2'd2);   // R4 IN in status
                         clr(); tok(2'd1); end
                4: begin sdone(0, 1); clr(); tok(2'd1); end          // R5 IN before ACK
                5: begin sdone(0, 1); clr(); tok(2'd2); rx(1'b0); end // R5 first DATA0
                6: begin sdone(0, 1); tok(2'd2); rx(1'b1); ack();    // R6 write status OUT
                         tok(2'd1); clr(); tok(2'd2); end
                default: begin sdone(0, 0); clr(); tok(2'd3); end    // R6 no-data PING
            endcase
            chk("R3-6 error stage R7", stage, 6);
            chk("R7 stall", resp_pid, 2);
            chk("R10 err bit", irq_sts, 8);
            tok(2'd0); tok(2'd1); ack(); tok(2'd2);
            chk("R7 held", stage, 6);
            chk("R7 stall held", resp_pid, 2);
            if ((idx & 1) == 0) begin
                sdone(rd[0], rw[0]);
                chk("R8 no early bit", irq_sts, 8);
                chk("R8 still held", stage, 6);
                clr();
                chk("R8 routed", stage, route(rd, rw));
                chk("R8 setup bit", irq_sts, 1);
                chk("R8 resp", resp_pid, 1);
            end else begin
                clr();
                chk("R9 back to idle", stage, 0);
                chk("R9 stall kept", resp_pid, 2);
                chk("R9 sts cleared", irq_sts, 0);
                tok(2'd0);
                chk("R9 stall cleared", resp_pid, 1);
            end
            clr();
        end

        // R9: SETUP token in mid-transfer restarts
        tok(2'd0); sdone(0, 1); tok(2'd2); rx(1'b1); ack();
        tok(2'd0);
        chk("R9 mid restart", stage, 0);
        sdone(1, 0);
        chk("R9 new route", stage, 5);

        // R10: masked error sets nothing, stage still 110
        clr();
        int_en = 4'h0;
        tok(2'd2);
        chk("R7 masked err stage", stage, 6);
        chk("R10 masked sts", irq_sts, 0);
        chk("R10 masked irq", irq, 0);
        clr();
        chk("R9 idle after clear", stage, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule